// File: doc/BRIEF.md
# Banked Register File with Pointer-Based Indirect Access

This block is the data register file of a small 8-bit controller core. It holds 72 general-purpose bytes, a handful of special slots and a 7-bit pointer register. Every access resolves to a 7-bit effective address. The upper two bits of that address choose one of four banks and the lower five bits choose a location within the bank. A direct access takes its five location bits from the instruction field and its bank bits from the pointer. An indirect access takes all seven bits from the pointer.

The low half of every bank (locations 00h to 0Fh) is shared: in banks 1 to 3 it reaches the same bytes as bank 0. Only the upper half (10h to 1Fh) of each upper bank holds storage of its own. Location 00h is a window with no storage behind it. Reaching it sends the access through the pointer. If the pointer names that window again, a read yields zero and a write is dropped. The pointer lives at location 04h and is also brought out as a port.

Reads are combinational from the current inputs. Writes take effect on the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: A direct access (useIndirect=0, dirAddr nonzero) reaches bank pointer[6:5] at location dirAddr. An indirect access uses pointer[6:0] as bank (bits 6:5) and location (bits 4:0).
- R2: Locations 01h to 0Fh reach the same storage in every bank, so a value written through bank 0 reads back through banks 1, 2 and 3.
- R3: Locations 10h to 1Fh are separate bytes in each of the four banks. Bank 0 holds general bytes at 08h to 1Fh and each upper bank adds 16 more, for 72 general bytes.
- R4: Asserting useIndirect, or a direct access to location 00h, routes the access through the pointer.
- R5: A pointer-routed read whose pointer location bits [4:0] are 00000 returns 00h.
- R6: A pointer-routed write whose pointer location bits [4:0] are 00000 changes no stored byte and leaves the pointer unchanged.
- R7: The pointer sits at location 04h. A write there loads bits 6:0 from wrData. A read of it, and ptrValue, return bit 7 as 1 above the 7 stored bits.
- R8: After reset the pointer holds 00h (ptrValue reads 80h), and the placeholder special slots 01h-03h and 05h-07h read 00h. Those placeholders store any byte written to them.
- R9: rdData follows the address inputs within the same cycle. A write lands on the rising clock edge only while wrEn is 1, and with wrEn at 0 nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| useIndirect | input | 1 | 1 routes the access through the pointer |
| dirAddr | input | 5 | Location field for direct accesses |
| wrEn | input | 1 | Write strobe for the addressed byte |
| wrData | input | 8 | Byte to be written |
| rdData | output | 8 | Byte at the addressed location |
| ptrValue | output | 8 | Pointer register as read, bit 7 forced to 1 |

## Verification
The assertions assume that wrEn, useIndirect, dirAddr and wrData settle before each rising edge and stay put through it. The bench changes them only on the falling edge. The properties also take for granted that the general bytes are never read before being written, because they carry no reset value. The stimulus table therefore writes every general location it later reads. It then checks cross-bank aliasing and pointer self-reference in both directions using only values it placed there itself.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  localparam int DATA_W      = 8;
  localparam int LOC_W       = 5;
  localparam int BANK_W      = 2;
  localparam int NUM_SPECIAL = 8;
  localparam int PTR_SLOT    = 4;

  localparam int ADDR_W      = BANK_W + LOC_W;
  localparam int NUM_BANKS   = 2 ** BANK_W;
  localparam int LOCS        = 2 ** LOC_W;
  localparam int SHARED      = LOCS / 2;
  localparam int BANK0_GEN   = LOCS - NUM_SPECIAL;
  localparam int UPPER_GEN   = LOCS - SHARED;
  localparam int GEN_TOTAL   = BANK0_GEN + (NUM_BANKS - 1) * UPPER_GEN;
  localparam int GEN_IDX_W   = $clog2(GEN_TOTAL);
  localparam int SPEC_W      = $clog2(NUM_SPECIAL);

  typedef struct packed {
    logic                 hitNull;
    logic                 hitSpecial;
    logic                 hitGeneral;
    logic [SPEC_W-1:0]    specSel;
    logic [GEN_IDX_W-1:0] genIdx;
    logic                 wrStrobe;
  } acc_t;
endpackage

// File: rtl/banked_regfile_ctrl.sv
module banked_regfile_ctrl
  import banked_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              useIndirect,
  input  logic [LOC_W-1:0]  dirAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] ptrAddr,
  output acc_t              acc
);
  logic              viaPtr;
  logic [ADDR_W-1:0] effAddr;
  logic [LOC_W-1:0]  loc;
  logic [BANK_W-1:0] bank;
  int                idxCalc;

  always_comb begin
    viaPtr  = useIndirect || (dirAddr == '0);
    effAddr = viaPtr ? ptrAddr : {ptrAddr[ADDR_W-1 -: BANK_W], dirAddr};
    loc     = effAddr[LOC_W-1:0];
    bank    = effAddr[ADDR_W-1 -: BANK_W];
    idxCalc = 0;
    acc     = '0;
    if (loc == '0) begin
      acc.hitNull = 1'b1;
    end else if (int'(loc) < NUM_SPECIAL) begin
      acc.hitSpecial = 1'b1;
      acc.specSel    = loc[SPEC_W-1:0];
    end else begin
      acc.hitGeneral = 1'b1;
      if (int'(loc) < SHARED || bank == '0)
        idxCalc = int'(loc) - NUM_SPECIAL;
      else
        idxCalc = BANK0_GEN + (int'(bank) - 1) * UPPER_GEN + (int'(loc) - SHARED);
      acc.genIdx = idxCalc[GEN_IDX_W-1:0];
    end
    acc.wrStrobe = wrEn && !acc.hitNull;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones({acc.hitNull, acc.hitSpecial, acc.hitGeneral}) == 1); // R4

  AST_GEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    acc.hitGeneral |-> (int'(acc.genIdx) < GEN_TOTAL)); // R3
endmodule

// File: rtl/banked_regfile_dp.sv
module banked_regfile_dp
  import banked_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  acc_t              acc,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ptrAddr,
  output logic [DATA_W-1:0] ptrValue
);
  logic [DATA_W-1:0] specRead [NUM_SPECIAL];
  logic [DATA_W-1:0] genMem   [GEN_TOTAL];
  logic [ADDR_W-1:0] ptrReg;

  for (genvar g = 0; g < NUM_SPECIAL; g++) begin : g_slot
    if (g == 0) begin : g_window
      assign specRead[g] = '0;
    end else if (g == PTR_SLOT) begin : g_ptr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          ptrReg <= '0;
        else if (acc.wrStrobe && acc.hitSpecial && int'(acc.specSel) == g)
          ptrReg <= wrData[ADDR_W-1:0];
      end
      assign specRead[g] = {{(DATA_W-ADDR_W){1'b1}}, ptrReg};
    end else begin : g_hold
      logic [DATA_W-1:0] slotReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          slotReg <= '0;
        else if (acc.wrStrobe && acc.hitSpecial && int'(acc.specSel) == g)
          slotReg <= wrData;
      end
      assign specRead[g] = slotReg;
    end
  end

  always_ff @(posedge clk) begin
    if (acc.wrStrobe && acc.hitGeneral)
      genMem[acc.genIdx] <= wrData;
  end

  always_comb begin
    if (acc.hitSpecial)
      rdData = specRead[acc.specSel];
    else if (acc.hitGeneral)
      rdData = genMem[acc.genIdx];
    else
      rdData = '0;
  end

  assign ptrAddr  = ptrReg;
  assign ptrValue = specRead[PTR_SLOT];

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (acc.wrStrobe && acc.hitSpecial && int'(acc.specSel) == PTR_SLOT)
      |=> (ptrAddr == $past(wrData[ADDR_W-1:0]))); // R7

  AST_NULL_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    acc.hitNull |=> (ptrAddr == $past(ptrAddr))); // R6
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              useIndirect,
  input  logic [LOC_W-1:0]  dirAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ptrValue
);
  acc_t              acc;
  logic [ADDR_W-1:0] ptrAddr;

  banked_regfile_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .useIndirect(useIndirect),
    .dirAddr    (dirAddr),
    .wrEn       (wrEn),
    .ptrAddr    (ptrAddr),
    .acc        (acc)
  );

  banked_regfile_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .acc     (acc),
    .wrData  (wrData),
    .rdData  (rdData),
    .ptrAddr (ptrAddr),
    .ptrValue(ptrValue)
  );

  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (useIndirect && ptrValue[LOC_W-1:0] == '0) |-> (rdData == '0)); // R5

  AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ptrValue)); // R9
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 46;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       useIndirect = 1'b0;
  logic [4:0] dirAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] ptrValue;

  int checks = 0;
  int failures = 0;

  banked_regfile u_banked_regfile (
    .clk(clk), .rstN(rstN), .useIndirect(useIndirect), .dirAddr(dirAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .ptrValue(ptrValue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] mk(input logic chk, input logic ind,
      input logic [4:0] a, input logic we, input logic [7:0] wd, input logic [7:0] ex);
    return {chk, ind, a, we, wd, ex};
  endfunction

  // {check, indirect, addr, we, wdata, expected}
  localparam logic [23:0] VEC [NVEC] = '{
    mk(0,0,5'h04,1,8'h00,8'h00), // pointer -> bank 0
    mk(0,0,5'h0A,1,8'h11,8'h00),
    mk(0,0,5'h15,1,8'h22,8'h00),
    mk(0,0,5'h02,1,8'h3C,8'h00),
    mk(0,0,5'h04,1,8'h20,8'h00), // bank 1
    mk(1,0,5'h0A,0,8'h00,8'h11), // R2 alias
    mk(1,0,5'h04,0,8'h00,8'hA0), // R7
    mk(0,0,5'h15,1,8'h33,8'h00),
    mk(1,0,5'h15,0,8'h00,8'h33), // R3
    mk(1,0,5'h02,0,8'h00,8'h3C), // R8 placeholder
    mk(0,0,5'h04,1,8'h75,8'h00), // bank 3 loc 15
    mk(0,1,5'h00,1,8'h44,8'h00),
    mk(1,1,5'h00,0,8'h00,8'h44), // R1 indirect
    mk(0,0,5'h04,1,8'h35,8'h00),
    mk(1,1,5'h00,0,8'h00,8'h33), // R3 bank 1
    mk(0,0,5'h04,1,8'h15,8'h00),
    mk(1,1,5'h00,0,8'h00,8'h22), // R3 bank 0
    mk(1,0,5'h15,0,8'h00,8'h22), // R1 direct bank 0
    mk(0,0,5'h04,1,8'h6A,8'h00), // bank 3 loc 0A
    mk(1,1,5'h00,0,8'h00,8'h11), // R2
    mk(0,1,5'h00,1,8'h55,8'h00),
    mk(1,0,5'h0A,0,8'h00,8'h55), // R2
    mk(1,0,5'h00,0,8'h00,8'h55), // R4 location 00h
    mk(0,0,5'h04,1,8'h40,8'h00), // bank 2 loc 00
    mk(1,1,5'h00,0,8'h00,8'h00), // R5
    mk(0,1,5'h00,1,8'h99,8'h00),
    mk(1,0,5'h04,0,8'h00,8'hC0), // R6
    mk(1,0,5'h0A,0,8'h00,8'h55), // R6
    mk(0,0,5'h04,1,8'h04,8'h00), // self
    mk(1,1,5'h00,0,8'h00,8'h84), // R7
    mk(0,1,5'h00,1,8'h12,8'h00),
    mk(1,0,5'h04,0,8'h00,8'h92), // R7
    mk(0,0,5'h04,1,8'hFF,8'h00),
    mk(1,0,5'h04,0,8'h00,8'hFF), // R7
    mk(0,1,5'h00,1,8'h66,8'h00),
    mk(1,0,5'h1F,0,8'h00,8'h66), // R1 bank 3
    mk(0,0,5'h04,1,8'h5F,8'h00),
    mk(0,1,5'h00,1,8'h77,8'h00),
    mk(1,1,5'h00,0,8'h00,8'h77), // R3
    mk(0,0,5'h04,1,8'h7F,8'h00),
    mk(1,1,5'h00,0,8'h00,8'h66), // R3
    mk(0,0,5'h04,1,8'h08,8'h00),
    mk(0,1,5'h00,1,8'hA5,8'h00),
    mk(1,0,5'h08,0,8'h00,8'hA5), // R3 lowest
    mk(0,0,5'h08,0,8'hFF,8'h00),
    mk(1,0,5'h08,0,8'h00,8'hA5)  // R9 wrEn low
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic drive(input logic ind, input logic [4:0] a, input logic we, input logic [7:0] wd);
    @(negedge clk);
    useIndirect = ind; dirAddr = a; wrEn = we; wrData = wd;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog R9 got=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    drive(0, 5'h04, 0, 8'h00);
    check("R8 ptrValue after reset", ptrValue, 8'h80);
    check("R8 pointer slot read", rdData, 8'h80);
    drive(0, 5'h03, 0, 8'h00);
    check("R8 placeholder reset", rdData, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][22], VEC[i][21:17], VEC[i][16], VEC[i][15:8]);
      if (VEC[i][23]) check($sformatf("R1-table step %0d", i), rdData, VEC[i][7:0]);
    end

    drive(0, 5'h04, 1, 8'h2B);
    drive(0, 5'h04, 0, 8'h00);
    check("R7 ptrValue port", ptrValue, 8'hAB);
    drive(0, 5'h05, 1, 8'h5A);
    drive(0, 5'h05, 0, 8'h00);
    check("R8 placeholder 05h", rdData, 8'h5A);

    @(negedge clk);
    rstN = 1'b0;
    #(CLK_PERIOD/4);
    check("R8 ptrValue in reset", ptrValue, 8'h80);
    @(negedge clk);
    rstN = 1'b1;
    drive(0, 5'h02, 0, 8'h00);
    check("R8 placeholder 02h cleared", rdData, 8'h00);
    drive(0, 5'h05, 0, 8'h00);
    check("R8 placeholder 05h cleared", rdData, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule